// File: doc/BRIEF.md
# Lane-Interleaved Masked Vector Multiplier

This block multiplies two integer vectors element by element and writes the products into a third vector. All three vectors live in a small vector register file inside the block. That file has eight registers of up to 64 elements, each element 32 bits wide. The file is split across parallel lanes: element i sits in lane (i mod LANES) at row (i / LANES). Each lane reads its own operands and runs a fully pipelined six-stage multiplier that accepts a new element every clock. Elements of one operation are independent, so the lanes never wait on each other and no hazard logic is needed.

A command gives two source register numbers, a destination register number, a vector length and a 64-bit element mask. Only elements below the length whose mask bit is set are written back. All other destination elements keep their old values. A simple host port loads and reads single elements of any register by register number and element index. A one-cycle pulse on `done` marks the end of an operation.

Top module: `vmul_lanes`

## Requirements
- R1: After an operation, destination element i (i below the effective length and mask bit i set) equals the low 32 bits of the unsigned product of source A element i and source B element i.
- R2: Mask bit i of `vmask` governs element i. A destination element whose mask bit is 0 keeps its previous value.
- R3: Destination elements at index i >= effective length keep their previous value. A length of 0 writes nothing.
- R4: With N = ceil(Leff/4) issue groups (4 lanes, six-stage multiply), `done` is high for exactly one cycle. It rises N+7 clock edges after the edge that samples `start`, and `busy` is already low in that cycle.
- R5: `busy` is high from the edge that samples `start` until `done`. A `start` that arrives while `busy` is high is ignored.
- R6: A host write that arrives while `busy` is high is ignored.
- R7: `host_rdata` shows element `host_idx` of register `host_reg`, as sampled on the previous clock edge (one cycle of read latency). Element i is stored in lane i mod 4 at row i/4.
- R8: The destination may equal a source register. The results are then computed from the source values that were present before the operation.
- R9: After reset, `busy`, `done` and `host_rdata` are all 0.
- R10: A length above 64 is treated as 64 (Leff = min(vlen, 64)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| src_a | input | 3 | First source register number |
| src_b | input | 3 | Second source register number |
| dst_reg | input | 3 | Destination register number |
| vlen | input | 7 | Vector length, clamped to 64 |
| vmask | input | 64 | Per-element write mask, bit i for element i |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| host_we | input | 1 | Host element write strobe |
| host_reg | input | 3 | Host register number |
| host_idx | input | 6 | Host element index |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after address |

## Verification
The assertions assume two things about the inputs. First, the command fields are only meaningful on the cycle `start` is sampled while idle. Second, no new command arrives until `done` has been seen, so the latched length and mask stay the same while write-backs are in flight. The stimulus raises each command for a single cycle at idle and waits for `done` before the next one. The only deliberate violations are one `start` and one host write issued while busy, and their effects are checked at the host read port. Lengths of 0, 1, 4, 5, 13, 37, 64 and 100 cover the group and clamp boundaries.

// File: rtl/vmul_pkg.sv
package vmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } vm_state_e;
endpackage

// File: rtl/vmul_ctrl.sv
module vmul_ctrl #(
  parameter int LANES  = 4,
  parameter int NREGS  = 8,
  parameter int MAXVL  = 64,
  parameter int STAGES = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start,
  input  logic [$clog2(NREGS)-1:0]        src_a,
  input  logic [$clog2(NREGS)-1:0]        src_b,
  input  logic [$clog2(NREGS)-1:0]        dst_reg,
  input  logic [$clog2(MAXVL+1)-1:0]      vlen,
  input  logic [MAXVL-1:0]                vmask,
  output logic                            busy,
  output logic                            done,
  output logic                            issue,
  output logic [$clog2(MAXVL/LANES)-1:0]  row,
  output logic [$clog2(NREGS)-1:0]        sa_q,
  output logic [$clog2(NREGS)-1:0]        sb_q,
  output logic [$clog2(NREGS)-1:0]        dst_q,
  output logic [$clog2(MAXVL+1)-1:0]      vlen_q,
  output logic [MAXVL-1:0]                vmask_q
);
  import vmul_pkg::*;

  localparam int LW   = $clog2(MAXVL + 1);
  localparam int LNW  = $clog2(LANES);
  localparam int ROWS = MAXVL / LANES;
  localparam int ROWW = $clog2(ROWS);
  localparam int DW   = $clog2(STAGES + 1);

  vm_state_e       state;
  logic [ROWW-1:0] last_q;
  logic [DW-1:0]   drain;
  logic [LW-1:0]   len_eff;
  logic [LW-1:0]   groups;

  // clamp the requested length, then count lane groups
  always_comb begin
    len_eff = (vlen > LW'(MAXVL)) ? LW'(MAXVL) : vlen;
    groups  = (len_eff + LW'(LANES - 1)) >> LNW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      row     <= '0;
      drain   <= '0;
      last_q  <= '0;
      sa_q    <= '0;
      sb_q    <= '0;
      dst_q   <= '0;
      vlen_q  <= '0;
      vmask_q <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            sa_q    <= src_a;
            sb_q    <= src_b;
            dst_q   <= dst_reg;
            vlen_q  <= len_eff;
            vmask_q <= vmask;
            last_q  <= ROWW'(groups - LW'(1));
            row     <= '0;
            drain   <= '0;
            state   <= (len_eff == '0) ? ST_DRAIN : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (row == last_q) begin
            drain <= '0;
            state <= ST_DRAIN;
          end else begin
            row <= row + ROWW'(1);
          end
        end
        ST_DRAIN: begin
          if (drain == DW'(STAGES)) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            drain <= drain + DW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (state != ST_IDLE);
  assign issue = (state == ST_ISSUE);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_start_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  p_row_bound_r3: assert property (@(posedge clk) disable iff (rst)
    issue |-> (LW'({row, {LNW{1'b0}}}) < vlen_q));
endmodule

// File: rtl/vmul_lane.sv
module vmul_lane #(
  parameter int LANE   = 0,
  parameter int LANES  = 4,
  parameter int NREGS  = 8,
  parameter int MAXVL  = 64,
  parameter int EW     = 32,
  parameter int STAGES = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            busy,
  input  logic                            issue,
  input  logic [$clog2(MAXVL/LANES)-1:0]  row,
  input  logic [$clog2(NREGS)-1:0]        sa,
  input  logic [$clog2(NREGS)-1:0]        sb,
  input  logic [$clog2(NREGS)-1:0]        dst,
  input  logic [$clog2(MAXVL+1)-1:0]      vlen_q,
  input  logic [MAXVL-1:0]                vmask_q,
  input  logic                            host_we,
  input  logic [$clog2(NREGS)-1:0]        host_reg,
  input  logic [$clog2(MAXVL/LANES)-1:0]  host_row,
  input  logic [EW-1:0]                   host_wdata,
  output logic [EW-1:0]                   host_rdata
);
  localparam int ROWS  = MAXVL / LANES;
  localparam int ROWW  = $clog2(ROWS);
  localparam int RW    = $clog2(NREGS);
  localparam int AW    = RW + ROWW;
  localparam int DEPTH = NREGS * ROWS;
  localparam int IW    = $clog2(MAXVL);
  localparam int LW    = $clog2(MAXVL + 1);
  localparam int LNW   = $clog2(LANES);

  logic [EW-1:0] mem [DEPTH];

  // element index handled by this lane in the current issue row
  logic [IW-1:0] elem;
  logic          take;
  assign elem = {row, LNW'(LANE)};
  assign take = issue && (LW'(elem) < vlen_q) && vmask_q[elem];

  // stage 1: operand read
  logic          v1;
  logic [AW-1:0] a1;
  logic [IW-1:0] e1;
  logic [EW-1:0] opa_q, opb_q;

  // stages 2..STAGES: product and delay
  logic          pv [2:STAGES];
  logic [AW-1:0] pa [2:STAGES];
  logic [IW-1:0] pe [2:STAGES];
  logic [EW-1:0] pd [2:STAGES];

  logic          pipe_we;
  logic          wen;
  logic [AW-1:0] waddr;
  logic [EW-1:0] wdata;

  assign pipe_we = pv[STAGES];
  assign wen     = pipe_we || host_we;
  assign waddr   = pipe_we ? pa[STAGES] : {host_reg, host_row};
  assign wdata   = pipe_we ? pd[STAGES] : host_wdata;

  // register bank: one write port, synchronous reads
  always_ff @(posedge clk) begin
    if (wen) mem[waddr] <= wdata;
    opa_q <= mem[{sa, row}];
    opb_q <= mem[{sb, row}];
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= mem[{host_reg, host_row}];
  end

  // valid chain
  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      for (int k = 2; k <= STAGES; k++) pv[k] <= 1'b0;
    end else begin
      v1    <= take;
      pv[2] <= v1;
      for (int k = 3; k <= STAGES; k++) pv[k] <= pv[k-1];
    end
  end

  // data chain
  always_ff @(posedge clk) begin
    a1    <= {dst, row};
    e1    <= elem;
    pa[2] <= a1;
    pe[2] <= e1;
    pd[2] <= EW'(opa_q * opb_q);
    for (int k = 3; k <= STAGES; k++) begin
      pa[k] <= pa[k-1];
      pe[k] <= pe[k-1];
      pd[k] <= pd[k-1];
    end
  end

  p_wb_in_len_r3: assert property (@(posedge clk) disable iff (rst)
    pipe_we |-> (LW'(pe[STAGES]) < vlen_q));
  p_wb_masked_r2: assert property (@(posedge clk) disable iff (rst)
    pipe_we |-> vmask_q[pe[STAGES]]);
  p_wb_busy_r5: assert property (@(posedge clk) disable iff (rst)
    pipe_we |-> busy);
  p_port_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(pipe_we && host_we));
endmodule

// File: rtl/vmul_lanes.sv
module vmul_lanes #(
  parameter int LANES  = 4,
  parameter int NREGS  = 8,
  parameter int MAXVL  = 64,
  parameter int EW     = 32,
  parameter int STAGES = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [$clog2(NREGS)-1:0]    src_a,
  input  logic [$clog2(NREGS)-1:0]    src_b,
  input  logic [$clog2(NREGS)-1:0]    dst_reg,
  input  logic [$clog2(MAXVL+1)-1:0]  vlen,
  input  logic [MAXVL-1:0]            vmask,
  output logic                        busy,
  output logic                        done,
  input  logic                        host_we,
  input  logic [$clog2(NREGS)-1:0]    host_reg,
  input  logic [$clog2(MAXVL)-1:0]    host_idx,
  input  logic [EW-1:0]               host_wdata,
  output logic [EW-1:0]               host_rdata
);
  localparam int ROWS = MAXVL / LANES;
  localparam int ROWW = $clog2(ROWS);
  localparam int RW   = $clog2(NREGS);
  localparam int LW   = $clog2(MAXVL + 1);
  localparam int IW   = $clog2(MAXVL);
  localparam int LNW  = $clog2(LANES);

  logic                   issue;
  logic [ROWW-1:0]        row;
  logic [RW-1:0]          sa_q, sb_q, dst_q;
  logic [LW-1:0]          vlen_q;
  logic [MAXVL-1:0]       vmask_q;
  logic [LNW-1:0]         host_lane;
  logic [ROWW-1:0]        host_row;
  logic [LNW-1:0]         rd_lane_q;
  logic [LANES-1:0][EW-1:0] lane_rd;

  assign host_lane = host_idx[LNW-1:0];
  assign host_row  = host_idx[IW-1:LNW];

  vmul_ctrl #(
    .LANES(LANES), .NREGS(NREGS), .MAXVL(MAXVL), .STAGES(STAGES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .src_a(src_a), .src_b(src_b), .dst_reg(dst_reg),
    .vlen(vlen), .vmask(vmask),
    .busy(busy), .done(done), .issue(issue), .row(row),
    .sa_q(sa_q), .sb_q(sb_q), .dst_q(dst_q),
    .vlen_q(vlen_q), .vmask_q(vmask_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hwe_g;
    assign hwe_g = host_we && !busy && (host_lane == LNW'(g));

    vmul_lane #(
      .LANE(g), .LANES(LANES), .NREGS(NREGS), .MAXVL(MAXVL),
      .EW(EW), .STAGES(STAGES)
    ) u_lane (
      .clk(clk), .rst(rst), .busy(busy), .issue(issue), .row(row),
      .sa(sa_q), .sb(sb_q), .dst(dst_q),
      .vlen_q(vlen_q), .vmask_q(vmask_q),
      .host_we(hwe_g), .host_reg(host_reg), .host_row(host_row),
      .host_wdata(host_wdata), .host_rdata(lane_rd[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_lane_q <= '0;
    else     rd_lane_q <= host_lane;
  end

  assign host_rdata = lane_rd[rd_lane_q];
endmodule

// File: tb/sim_vmul_lanes.sv
module sim_vmul_lanes;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  src_a = '0, src_b = '0, dst_reg = '0;
  logic [6:0]  vlen = '0;
  logic [63:0] vmask = '0;
  logic        busy, done;
  logic        host_we = 1'b0;
  logic [2:0]  host_reg = '0;
  logic [5:0]  host_idx = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;

  always #4 clk = ~clk;

  vmul_lanes u0 (
    .clk(clk), .rst(rst), .start(start),
    .src_a(src_a), .src_b(src_b), .dst_reg(dst_reg),
    .vlen(vlen), .vmask(vmask), .busy(busy), .done(done),
    .host_we(host_we), .host_reg(host_reg), .host_idx(host_idx),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] model [8][64];

  logic [31:0] exp_q [$];
  string       tag_q [$];
  int          loc_q [$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: compares read data one cycle after each queued request
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      int l;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      l = loc_q.pop_front();
      n_tests++;
      if (host_rdata !== e) begin
        n_fail++;
        $display("FAIL %s v%0d[%0d] actual=%0h expected=%0h", t, l / 64, l % 64, host_rdata, e);
      end
    end
  end

  task automatic hwrite(input int r, input int i, input logic [31:0] v);
    @(negedge clk);
    host_we = 1'b1; host_reg = 3'(r); host_idx = 6'(i); host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic check_reg(input int r, input string tag);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      host_reg = 3'(r); host_idx = 6'(i);
      @(posedge clk);
      exp_q.push_back(model[r][i]);
      tag_q.push_back(tag);
      loc_q.push_back(r * 64 + i);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_op(input int a, input int b, input int d, input int len,
                        input logic [63:0] m, input bit inject);
    logic [31:0] ca [64];
    logic [31:0] cb [64];
    int leff, ngrp, k;
    leff = (len > 64) ? 64 : len;
    ngrp = (leff + 3) / 4;
    for (int i = 0; i < 64; i++) begin ca[i] = model[a][i]; cb[i] = model[b][i]; end
    for (int i = 0; i < leff; i++)
      if (m[i]) model[d][i] = ca[i] * cb[i];
    @(negedge clk);
    start = 1'b1; src_a = 3'(a); src_b = 3'(b); dst_reg = 3'(d);
    vlen = 7'(len); vmask = m;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R5 busy after start", longint'(busy), 1);
    k = 0;
    while (done !== 1'b1 && k < 400) begin
      if (inject && k == 1) begin
        start = 1'b1; dst_reg = 3'd6; vlen = 7'd64; vmask = '1;
        host_we = 1'b1; host_reg = 3'd7; host_idx = 6'd5; host_wdata = 32'hDEAD_BEEF;
      end
      if (inject && k == 2) begin
        start = 1'b0; host_we = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      k++;
    end
    chk(k == ngrp + 7, "R4 done latency", k, ngrp + 7);
    chk(busy === 1'b0, "R4 busy low with done", longint'(busy), 0);
    @(negedge clk);
    chk(done === 1'b0, "R4 done single pulse", longint'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(busy === 1'b0, "R9 reset busy", longint'(busy), 0);
    chk(done === 1'b0, "R9 reset done", longint'(done), 0);
    chk(host_rdata === 32'h0, "R9 reset rdata", longint'(host_rdata), 0);

    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 64; i++) begin
        model[r][i] = (32'(i) + 32'd1) * 32'h9E37_79B1 ^ (32'(r) * 32'h0101_0193);
        hwrite(r, i, model[r][i]);
      end
    check_reg(0, "R7");
    check_reg(5, "R7");

    run_op(0, 1, 2, 64, '1, 1'b0);
    check_reg(2, "R1");

    run_op(0, 5, 3, 13, 64'hF0F0_0F0F_5555_AAAA, 1'b0);
    check_reg(3, "R2 R3");

    run_op(2, 3, 1, 0, '1, 1'b0);
    check_reg(1, "R3");

    run_op(4, 5, 4, 37, 64'h3333_CCCC_FFFF_7777, 1'b1);
    check_reg(4, "R8");
    check_reg(6, "R5");
    check_reg(7, "R6");

    run_op(0, 0, 6, 1, '1, 1'b0);
    run_op(1, 2, 5, 4, '1, 1'b0);
    run_op(3, 4, 0, 5, '1, 1'b0);
    run_op(1, 2, 7, 100, '1, 1'b0);
    check_reg(7, "R10");

    for (int r = 0; r < 8; r++) check_reg(r, "R1");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule